// File: doc/BRIEF.md
# Super-Pixel Hit Packet Builder

This block serves one logic cell shared by a 2-column by 4-row group of binary pixels. In every clock cycle, which stands for one bunch crossing, it samples the eight pixel hit strobes. If any strobe is set, it forms one 30-bit packet. The packet holds the group's fixed address, the 9-bit bunch counter value of that crossing and an 8-bit map of which pixels fired. Pixels are binary, so the packet carries no charge or amplitude.

Finished packets go into a two-entry local buffer. They are offered to the column readout bus at once, with no trigger. The output is a valid/ready stream. A packet stays offered, unchanged, until the cycle in which `pkt_ready_i` is high while `pkt_valid_o` is high. Back-pressure from the bus fills the buffer. Once both entries are occupied and none is leaving, the hits of a new crossing are dropped and counted in a saturating lost-packet counter. A synchronous clear empties the buffer.

Top module: `sp_packet_builder`

## Requirements
- R1: After reset, `pkt_valid_o` is low and `lost_cnt_o` is zero.
- R2: Packet layout from the most significant bit: bits 29:17 carry `grp_addr_i`, bits 16:8 carry `bcid_i` of the hit cycle, and bits 7:0 carry the hit map.
- R3: All strobes set in one cycle are merged into a single packet whose map bit i equals strobe i (pixel 0 in bit 0). A cycle with no strobe set forms no packet, so an offered packet never has an all-zero map.
- R4: A packet formed in cycle t into an empty buffer is offered with `pkt_valid_o` high from cycle t+1.
- R5: The buffer holds at most 2 packets and offers them oldest first.
- R6: When a cycle has hits, both entries are full and no transfer happens, that cycle's packet is discarded and `lost_cnt_o` rises by exactly one.
- R7: `lost_cnt_o` saturates at its all-ones value and does not wrap.
- R8: An entry is freed in the cycle where valid and ready are both high. A packet formed in that same cycle is stored even when the buffer was full, and it is not counted as lost.
- R9: While `pkt_valid_o` is high and `pkt_ready_i` is low, the offered packet and its valid stay unchanged in the next cycle.
- R10: A synchronous `clear_i` empties both entries, so `pkt_valid_o` is low in the next cycle. Hits in the clear cycle are neither stored nor counted, and `lost_cnt_o` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one cycle per bunch crossing |
| rst_n | input | 1 | Asynchronous active-low reset |
| clear_i | input | 1 | Synchronous buffer clear |
| hit_i | input | 8 | Pixel hit strobes, bit i = pixel i |
| bcid_i | input | 9 | Bunch counter value of the current crossing |
| grp_addr_i | input | 13 | Fixed address of the pixel group |
| pkt_valid_o | output | 1 | A packet is offered |
| pkt_ready_i | input | 1 | The column bus takes the offered packet |
| pkt_data_o | output | 30 | Offered packet |
| lost_cnt_o | output | 8 | Saturating count of dropped packets |

## Verification
The hardest situations to reach are two. The first is a full buffer meeting a transfer and a new hit in the same cycle, which must not be counted as lost. The second is the lost counter reaching its ceiling, which needs hundreds of consecutive dropped crossings. Directed sequences hold ready low while hits arrive every cycle, then raise ready together with a new hit. A long stalled burst drives the counter past its maximum. Random hits, ready and rare clears, checked against a reference queue, then mix these situations with ordinary traffic.

// File: rtl/sp_pkg.sv
package sp_pkg;
  localparam int unsigned SP_COLS = 2;
  localparam int unsigned SP_ROWS = 4;
  localparam int unsigned NPIX    = SP_COLS * SP_ROWS;
  localparam int unsigned TS_W    = 9;
  localparam int unsigned ADDR_W  = 13;
  localparam int unsigned PKT_W   = ADDR_W + TS_W + NPIX;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [TS_W-1:0]   ts;
    logic [NPIX-1:0]   map;
  } sp_pkt_t;
endpackage

// File: rtl/sp_packet_former.sv
module sp_packet_former
  import sp_pkg::*;
(
  input  logic [NPIX-1:0]   hit_i,
  input  logic [TS_W-1:0]   bcid_i,
  input  logic [ADDR_W-1:0] addr_i,
  output sp_pkt_t           pkt_o,
  output logic              any_o
);
  // one packet per crossing: all simultaneous strobes share one timestamp
  always_comb begin
    pkt_o.addr = addr_i;
    pkt_o.ts   = bcid_i;
    pkt_o.map  = hit_i;
    any_o      = |hit_i;
  end
endmodule

// File: rtl/sp_pkt_fifo.sv
module sp_pkt_fifo
  import sp_pkg::*;
#(
  parameter int unsigned DEPTH = 2
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    clear_i,
  input  logic    push_i,
  input  sp_pkt_t din_i,
  input  logic    ready_i,
  output logic    valid_o,
  output sp_pkt_t dout_o,
  output logic    drop_o
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  sp_pkt_t            mem [DEPTH];
  logic [PTR_W-1:0]   wr_ptr, rd_ptr;
  logic [CNT_W-1:0]   count;
  logic               pop, room, accept;

  assign valid_o = (count != '0);
  assign dout_o  = mem[rd_ptr];
  assign pop     = valid_o && ready_i && !clear_i;
  assign room    = (count < CNT_W'(DEPTH)) || pop;
  assign accept  = push_i && room && !clear_i;
  assign drop_o  = push_i && !room && !clear_i;

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    always_ff @(posedge clk) begin
      if (accept && wr_ptr == PTR_W'(g)) mem[g] <= din_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else if (clear_i) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (accept) wr_ptr <= nxt(wr_ptr);
      if (pop)    rd_ptr <= nxt(rd_ptr);
      case ({accept, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(DEPTH)); // R5
  AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> !valid_o); // R10
  AST_FULL_SWAP: assert property (@(posedge clk) disable iff (!rst_n)
    (count == CNT_W'(DEPTH) && push_i && valid_o && ready_i && !clear_i) |=> count == CNT_W'(DEPTH)); // R8
endmodule

// File: rtl/sp_loss_counter.sv
module sp_loss_counter #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);
  localparam logic [W-1:0] MAXV = '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      cnt_o <= '0;
    else if (inc_i && cnt_o != MAXV) cnt_o <= cnt_o + 1'b1;
  end

  AST_LOSS_SAT: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_o == MAXV) |=> (cnt_o == MAXV)); // R7
  AST_LOSS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (cnt_o == $past(cnt_o) || cnt_o == $past(cnt_o) + 1'b1)); // R6
endmodule

// File: rtl/sp_packet_builder.sv
module sp_packet_builder
  import sp_pkg::*;
#(
  parameter int unsigned DEPTH  = 2,
  parameter int unsigned LOSS_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear_i,
  input  logic [NPIX-1:0]   hit_i,
  input  logic [TS_W-1:0]   bcid_i,
  input  logic [ADDR_W-1:0] grp_addr_i,
  output logic              pkt_valid_o,
  input  logic              pkt_ready_i,
  output logic [PKT_W-1:0]  pkt_data_o,
  output logic [LOSS_W-1:0] lost_cnt_o
);
  sp_pkt_t new_pkt, head_pkt;
  logic    any_hit, dropped;

  sp_packet_former u_former (
    .hit_i  (hit_i),
    .bcid_i (bcid_i),
    .addr_i (grp_addr_i),
    .pkt_o  (new_pkt),
    .any_o  (any_hit)
  );

  sp_pkt_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear_i (clear_i),
    .push_i  (any_hit),
    .din_i   (new_pkt),
    .ready_i (pkt_ready_i),
    .valid_o (pkt_valid_o),
    .dout_o  (head_pkt),
    .drop_o  (dropped)
  );

  sp_loss_counter #(.W(LOSS_W)) u_loss (
    .clk   (clk),
    .rst_n (rst_n),
    .inc_i (dropped),
    .cnt_o (lost_cnt_o)
  );

  assign pkt_data_o = head_pkt;

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_valid_o && !pkt_ready_i && !clear_i) |=> (pkt_valid_o && $stable(pkt_data_o))); // R9
  AST_MAP_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_valid_o |-> (pkt_data_o[NPIX-1:0] != '0)); // R3
endmodule

// File: tb/tb_sp_packet_builder.sv
module tb_sp_packet_builder;
  localparam int LOSS_W = 8;
  localparam int LMAX   = (1 << LOSS_W) - 1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        clear_i = 1'b0;
  logic [7:0]  hit_i = '0;
  logic [8:0]  bcid_i = '0;
  logic [12:0] grp_addr_i = 13'h1A5C;
  logic        pkt_valid_o;
  logic        pkt_ready_i = 1'b0;
  logic [29:0] pkt_data_o;
  logic [7:0]  lost_cnt_o;

  int checks = 0;
  int errors = 0;

  logic [29:0] mq [2];
  int m_cnt  = 0;
  int m_lost = 0;
  logic [8:0] bc = '0;

  sp_packet_builder #(.DEPTH(2), .LOSS_W(LOSS_W)) dut (
    .clk(clk), .rst_n(rst_n), .clear_i(clear_i), .hit_i(hit_i),
    .bcid_i(bcid_i), .grp_addr_i(grp_addr_i), .pkt_valid_o(pkt_valid_o),
    .pkt_ready_i(pkt_ready_i), .pkt_data_o(pkt_data_o), .lost_cnt_o(lost_cnt_o)
  );

  always #5 clk = ~clk;

  function automatic logic [29:0] mk_pkt(input logic [12:0] a, input logic [8:0] t,
                                         input logic [7:0] m);
    return {a, t, m};
  endfunction

  task automatic chk(input longint act, input longint exp, input string tag);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // called at a negedge: compare, drive next inputs, advance model, move one cycle
  task automatic step(input logic [7:0] h, input logic rdy, input logic clr, input string tag);
    logic pop;
    chk(pkt_valid_o, m_cnt != 0, {tag, " valid"});
    if (m_cnt != 0) begin
      chk(pkt_data_o[29:17], mq[0][29:17], "R2 address field");
      chk(pkt_data_o[16:8], mq[0][16:8], "R2 timestamp field");
      chk(pkt_data_o[7:0], mq[0][7:0], "R3 hit map");
      chk(pkt_data_o, mq[0], {tag, " packet"});
    end
    chk(lost_cnt_o, m_lost, "R6 lost count");
    hit_i = h; pkt_ready_i = rdy; clear_i = clr; bcid_i = bc;
    if (clr) m_cnt = 0;
    else begin
      pop = (m_cnt != 0) && rdy;
      if (pop) begin mq[0] = mq[1]; m_cnt--; end
      if (h != 0) begin
        if (m_cnt < 2) begin mq[m_cnt] = mk_pkt(grp_addr_i, bc, h); m_cnt++; end
        else if (m_lost < LMAX) m_lost++;
      end
    end
    bc = bc + 9'd1;
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    int seed;
    seed = 32'h5EED_0042;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(pkt_valid_o, 0, "R1 valid after reset");
    chk(lost_cnt_o, 0, "R1 lost after reset");

    // R4: single hit shows one cycle later; R3 merged map
    step(8'b1000_0101, 1'b0, 1'b0, "R4");
    chk(pkt_valid_o, 1, "R4 valid one cycle after hit");
    step(8'h00, 1'b1, 1'b0, "R3");
    step(8'h00, 1'b0, 1'b0, "R3 empty cycle");
    chk(pkt_valid_o, 0, "R3 no packet without hits");

    // R5 ordering and R6 drop with stall; R9 hold
    step(8'h01, 1'b0, 1'b0, "R5");
    step(8'h80, 1'b0, 1'b0, "R9");
    step(8'h3C, 1'b0, 1'b0, "R9");
    chk(lost_cnt_o, 1, "R6 one drop when full");
    step(8'h00, 1'b0, 1'b0, "R9");
    step(8'h00, 1'b1, 1'b0, "R5 oldest first");
    chk(pkt_data_o[7:0], 8'h80, "R5 second packet next");
    // R8: refill to full, then pop and push same cycle
    step(8'h11, 1'b0, 1'b0, "R8");
    step(8'h22, 1'b1, 1'b0, "R8 swap");
    chk(lost_cnt_o, 1, "R8 no loss on swap");
    step(8'h00, 1'b1, 1'b0, "R8");
    chk(pkt_data_o[7:0], 8'h22, "R8 swapped packet stored");
    // R10 clear with hit in same cycle
    step(8'hFF, 1'b0, 1'b1, "R10");
    chk(pkt_valid_o, 0, "R10 empty after clear");
    chk(lost_cnt_o, 1, "R10 lost kept");
    step(8'h00, 1'b0, 1'b0, "R10");

    // random traffic
    for (int i = 0; i < 3000; i++) begin
      logic [7:0] h;
      h = ($urandom % 2 == 0) ? 8'h00 : 8'($urandom);
      step(h, ($urandom % 10) < 6, ($urandom % 100) == 0, "R5 random");
    end

    // R7 saturation: long stall with hits every crossing
    step(8'h00, 1'b0, 1'b1, "R7");
    for (int i = 0; i < 300; i++) step(8'($urandom) | 8'h01, 1'b0, 1'b0, "R7");
    chk(lost_cnt_o, LMAX, "R7 saturated");
    step(8'h40, 1'b0, 1'b0, "R7");
    chk(lost_cnt_o, LMAX, "R7 no wrap");
    for (int i = 0; i < 4; i++) step(8'h00, 1'b1, 1'b0, "R5 drain");
    chk(pkt_valid_o, 0, "R5 drained");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule